// File: doc/BRIEF.md
# Single Pulse Capture Gate

This block picks exactly one positive phase out of a free-running square wave each time a command is raised. The square wave and the command come from outside the system clock domain. Both are brought in through two-flop synchronizers and then examined for edges on the fast system clock. A command edge arms the block. The first complete high phase of the wave that starts after arming is copied to the pulse output, edge for edge. The block then disarms and waits for a new command edge.

A phase that is already in progress when the command arrives is never cut into a partial pulse. Holding the command high does not produce a second pulse. Command edges that come while the block is busy are dropped. The wave reaches the output gate through two delay stages, which line it up with the enable register. The output itself comes straight from a flip-flop, so it cannot glitch.

Top module: `pulse_trap`

## Requirements
In what follows, "sample i" is the input value present at clock edge i. A rise at sample i means the input is 1 at sample i and 0 at sample i-1.
- R1: A command rise at sample c, accepted while idle, drives busy high from the clock edge c+2 onward.
- R2: Once armed by a command rise at sample c, the first wave rise at a sample j > c starts the capture. If that high phase covers samples j to f-1 and the wave is 0 at sample f, then pulse_out is 1 after edges j+4 through f+3 and is 0 again after edge f+4.
- R3: A wave rise at the same sample as the command rise, or at an earlier one, is not passed, so a phase already high when the command arrives is skipped completely.
- R4: Each accepted command rise yields exactly one output pulse, however long the command stays high.
- R5: A command rise is ignored while the block is armed or passing, and also at any sample up to f+2 of the pulse that just ended.
- R6: busy falls after edge f+4, on the same edge as pulse_out.
- R7: pulse_out is never high unless busy is high, and with no accepted command the wave never reaches the output.
- R8: While the synchronous reset is high, pulse_out and busy read 0 at every edge, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_in | input | 1 | Asynchronous command; its rising edge requests one pulse |
| wave_in | input | 1 | Asynchronous square-wave input |
| pulse_out | output | 1 | Registered copy of one captured high phase |
| busy | output | 1 | High from arming until the captured pulse has ended |

## Verification
The results arrive at fixed delays. busy rises two edges after the command sample. The pulse copies the wave four edges late. busy and the pulse fall together four edges after the first low wave sample. The bench builds its expectations by working through the sampled input sequence one sample at a time, under the rules above. It then shifts each expected output by that requirement's latency and files it under the edge number where it is due. Outputs are read at the falling edge after each rising edge and compared with the entry for that edge. Directed segments also pin a handful of edge numbers, worked out by hand, for the skipped phase, the held command and the dropped command edges.

// File: rtl/pulse_trap_pkg.sv
package pulse_trap_pkg;

    localparam int CH_CMD  = 0;
    localparam int CH_WAVE = 1;
    localparam int N_CH    = 2;

    typedef struct packed {
        logic cmd_rise;
        logic wave_rise;
        logic wave_late;
    } evt_t;

    typedef struct packed {
        logic arm;
        logic en;
    } cap_t;

    function automatic logic rose(input logic now_v, input logic was_v);
        return now_v & ~was_v;
    endfunction

endpackage

// File: rtl/pt_sync.sv
module pt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= async_in;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[k] <= '0;
            else     stg[k] <= stg[k-1];
        end
    end

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/pt_events.sv
module pt_events
    import pulse_trap_pkg::*;
#(
    parameter int WAVE_DLY = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] lvl,
    output evt_t            evt
);
    logic                cmd_prev;
    logic [WAVE_DLY-1:0] wave_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_prev     <= 1'b0;
            wave_line[0] <= 1'b0;
        end else begin
            cmd_prev     <= lvl[CH_CMD];
            wave_line[0] <= lvl[CH_WAVE];
        end
    end

    for (genvar k = 1; k < WAVE_DLY; k++) begin : g_dly
        always_ff @(posedge clk) begin
            if (rst) wave_line[k] <= 1'b0;
            else     wave_line[k] <= wave_line[k-1];
        end
    end

    always_comb begin
        evt.cmd_rise  = rose(lvl[CH_CMD], cmd_prev);
        evt.wave_rise = rose(lvl[CH_WAVE], wave_line[0]);
        evt.wave_late = wave_line[WAVE_DLY-1];
    end

    // A detected wave rise cannot repeat on the very next cycle
    assert_rise_isolated_R2: assert property (@(posedge clk) disable iff (rst)
        evt.wave_rise |=> !evt.wave_rise);
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
    import pulse_trap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t evt,
    output logic pulse_q,
    output logic armed
);
    cap_t st, st_nx;
    logic done;

    // the delayed wave has gone low while the copied pulse is still high
    assign done = st.en & pulse_q & ~evt.wave_late;

    always_comb begin
        st_nx = st;
        if (done) begin
            st_nx = '0;
        end else begin
            if (evt.cmd_rise && !st.arm)                 st_nx.arm = 1'b1;
            if (st.arm && !st.en && evt.wave_rise)       st_nx.en  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            pulse_q <= 1'b0;
        end else begin
            st      <= st_nx;
            pulse_q <= st.en & evt.wave_late;
        end
    end

    assign armed = st.arm;

    assert_en_needs_arm_R2: assert property (@(posedge clk) disable iff (rst)
        st.en |-> st.arm);
    assert_arm_from_cmd_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(st.arm) |-> $past(evt.cmd_rise));
    assert_pulse_after_enable_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_q) |-> $past(st.en));
    assert_release_together_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_q) |-> !st.arm);
    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (!pulse_q && !st.arm && !st.en));
endmodule

// File: rtl/pulse_trap.sv
module pulse_trap
    import pulse_trap_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WAVE_DLY    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_in,
    input  logic wave_in,
    output logic pulse_out,
    output logic busy
);
    logic [N_CH-1:0] raw_lvl;
    logic [N_CH-1:0] syn_lvl;
    evt_t            evt;

    always_comb begin
        raw_lvl          = '0;
        raw_lvl[CH_CMD]  = cmd_in;
        raw_lvl[CH_WAVE] = wave_in;
    end

    pt_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(raw_lvl), .sync_out(syn_lvl)
    );

    pt_events #(.WAVE_DLY(WAVE_DLY)) u_evt (
        .clk(clk), .rst(rst), .lvl(syn_lvl), .evt(evt)
    );

    pt_ctrl u_ctrl (
        .clk(clk), .rst(rst), .evt(evt), .pulse_q(pulse_out), .armed(busy)
    );

    assert_pulse_within_busy_R7: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> busy);
endmodule

// File: tb/pulse_trap_tb.sv
module pulse_trap_tb;
    localparam int N    = 2400;
    localparam int NE   = N + 8;
    localparam int RAND0 = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_in = 1'b0;
    logic wave_in = 1'b0;
    logic pulse_out, busy;

    logic cmd_a  [N];
    logic wave_a [N];
    logic exp_p  [NE];
    logic exp_b  [NE];
    logic obs_p  [NE];
    logic obs_b  [NE];

    int checks = 0;
    int errors = 0;
    int model_pulses = 0;
    int seen_pulses = 0;

    always #10 clk = ~clk;

    pulse_trap u_dut (
        .clk(clk), .rst(rst), .cmd_in(cmd_in), .wave_in(wave_in),
        .pulse_out(pulse_out), .busy(busy)
    );

    function automatic logic rise_at(input logic cur, input logic prv);
        return cur & ~prv;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input int edge_n);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s edge %0d: actual %0b expected %0b", tag, edge_n, act, exp);
        end
    endtask

    // Reference built sample by sample from the requirements
    task automatic build_expect();
        int st = 0;
        int arm_e = 0;
        int last_end = -100;
        for (int e = 0; e < NE; e++) begin
            exp_p[e] = 1'b0;
            exp_b[e] = 1'b0;
        end
        for (int i = 0; i < N; i++) begin
            logic c, w;
            c = rise_at(cmd_a[i], (i > 0) ? cmd_a[i-1] : 1'b0);
            w = rise_at(wave_a[i], (i > 0) ? wave_a[i-1] : 1'b0);
            case (st)
                0: if (c && i > last_end + 2) begin st = 1; arm_e = i + 2; end   // R1, R5
                1: if (w) st = 2;                                              // R2, R3
                default: if (!wave_a[i]) begin                                 // R6
                    st = 0;
                    last_end = i;
                    model_pulses++;
                    for (int e = arm_e; e <= i + 3; e++) exp_b[e] = 1'b1;
                end
            endcase
            if (st == 2 && wave_a[i]) exp_p[i+4] = 1'b1;
        end
        if (st != 0) for (int e = arm_e; e < NE; e++) exp_b[e] = 1'b1;
    endtask

    task automatic gen_stimulus();
        int pos;
        logic lv;
        void'($urandom(32'd57));
        for (int i = 0; i < N; i++) begin
            cmd_a[i] = 1'b0;
            wave_a[i] = 1'b0;
        end
        // directed: wave period 8, high on samples 0..3 of each period
        for (int i = 0; i < RAND0; i++) wave_a[i] = ((i % 8) < 4);
        for (int i = 10; i <= 100; i++) cmd_a[i] = 1'b1;   // rise mid-phase, long hold
        cmd_a[120] = 1'b1; cmd_a[121] = 1'b1;                // rise with the wave rise
        cmd_a[124] = 1'b1; cmd_a[125] = 1'b1;                // while armed
        cmd_a[130] = 1'b1; cmd_a[131] = 1'b1;                // while passing
        cmd_a[133] = 1'b1; cmd_a[134] = 1'b1;                // in the release window
        for (int i = 140; i < RAND0; i++) cmd_a[i] = 1'b1;
        // random segments
        pos = RAND0; lv = 1'b0;
        while (pos < N - 20) begin
            int len = 1 + $urandom_range(5, 0);
            for (int k = 0; k < len && pos < N - 20; k++) begin wave_a[pos] = lv; pos++; end
            lv = ~lv;
        end
        pos = RAND0; lv = 1'b0;
        while (pos < N - 20) begin
            int len = lv ? 1 + $urandom_range(30, 0) : 1 + $urandom_range(25, 0);
            for (int k = 0; k < len && pos < N - 20; k++) begin cmd_a[pos] = lv; pos++; end
            lv = ~lv;
        end
    endtask

    initial begin
        #(20ns * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        gen_stimulus();
        build_expect();
        for (int e = 0; e < NE; e++) begin obs_p[e] = 1'b0; obs_b[e] = 1'b0; end

        // R8: reset holds outputs low while inputs move
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cmd_in  = k[0];
            wave_in = ~k[0];
            if (k > 0) begin
                check("R8 pulse_out in reset", pulse_out, 1'b0, -1);
                check("R8 busy in reset", busy, 1'b0, -1);
            end
        end
        @(negedge clk);
        cmd_in = 1'b0; wave_in = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NE - 1; i++) begin
            if (i > 0) @(negedge clk);
            if (i > 0) begin
                obs_p[i-1] = pulse_out;
                obs_b[i-1] = busy;
                check("R2/R3/R4/R7 pulse_out", pulse_out, exp_p[i-1], i - 1);
                check("R1/R5/R6 busy", busy, exp_b[i-1], i - 1);
                if (i > 1 && pulse_out && !obs_p[i-2]) seen_pulses++;
            end
            cmd_in  = (i < N) ? cmd_a[i] : 1'b0;
            wave_in = (i < N) ? wave_a[i] : 1'b0;
        end

        // Hand-derived edges from the directed segment
        check("R7 wave without command", obs_p[4], 1'b0, 4);
        check("R1 busy before arm", obs_b[11], 1'b0, 11);
        check("R1 busy at arm", obs_b[12], 1'b1, 12);
        check("R3 mid-phase skipped", obs_p[14], 1'b0, 14);
        check("R2 pulse start", obs_p[20], 1'b1, 20);
        check("R2 pulse last", obs_p[23], 1'b1, 23);
        check("R6 pulse end", obs_p[24], 1'b0, 24);
        check("R6 busy end", obs_b[24], 1'b0, 24);
        check("R4 held command no second pulse", obs_p[28], 1'b0, 28);
        check("R3 same-sample rise skipped", obs_p[124], 1'b0, 124);
        check("R2 pulse after skip", obs_p[132], 1'b1, 132);
        check("R5 release window edge dropped", obs_b[140], 1'b0, 140);
        check("R1 rearm", obs_b[142], 1'b1, 142);
        check("R2 third pulse", obs_p[148], 1'b1, 148);
        check("R4 single pulse while held", obs_p[156], 1'b0, 156);
        checks++;
        if (seen_pulses != model_pulses) begin
            errors++;
            $display("FAIL R4 pulse count: actual %0d expected %0d", seen_pulses, model_pulses);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule